// File: doc/BRIEF.md
# Serial Command Decoder with Pixel Burst Auto-Increment

This block is the serial slave front end of a small segment-display controller. An external master frames each transaction with an active-low select line. The block decodes a four-bit header into a direction flag and a three-bit target code. It then serves one of two kinds of transfer.

The first kind is an open-ended stream into or out of a single-bit pixel store with 380 entries. The stream carries a start address, which then advances on its own after each pixel. The second kind is a fixed twelve-bit access to one of six control words.

The serial pins are asynchronous to the system clock. The block synchronises them and acts on the edges it detects. It contains the pixel store and the control-word bank, and both are reached only through the serial port.

Top module: `pixspi_cmd_dec`

## Requirements
- R1: While select is high the decoder returns to header parsing, and MISO is held at 0. Driving select low starts a new transaction.
- R2: The first bit of a transaction is the direction flag, where 0 means write and 1 means read. The next three bits, MSB first, form the target code. Code 000 selects pixels, codes 010 through 111 select control words, and code 001 is reserved.
- R3: After code 000 the decoder takes a 10-bit start address, MSB first. It then skips two padding bits, whose values have no effect. Every later bit is one pixel.
- R4: The pixel address advances by one after every pixel bit, so a single transaction can move any number of consecutive pixels.
- R5: A start address of 380 or more is replaced by 0, and the address that follows 379 is 0.
- R6: A control-word access carries exactly 12 data bits, MSB first. A write takes effect when the twelfth bit arrives, and any further bits in the same transaction are ignored.
- R7: MOSI is sampled on rising SCLK edges and MISO changes only on falling SCLK edges. Each read data bit, including the first one, is present on MISO before the rising edge of its slot.
- R8: Writes to code 001 have no effect, and reads of code 001 return twelve zero bits.
- R9: Raising select before the twelfth bit of a control-word write leaves that word unchanged.
- R10: After reset, every control word and every pixel reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |

## Verification
The bench runs bursts that cross the top of the pixel store, as well as a start address above the store. A design with a faulty wrap would write beyond the last entry or restart at the wrong address, and the read-back stream would then differ. It sends padding bits of both polarities, control writes that stop early or run past twelve bits, and accesses to the reserved code. Each of these exposes a decoder that counts bits wrongly or commits data too soon. Every read is compared bit by bit, including the first data bit. This catches a MISO driver that lags by one edge or that drives the wrong source.

// File: rtl/pixspi_pkg.sv
package pixspi_pkg;
    localparam int PIX_DEPTH = 380;
    localparam int ADDR_W    = 10;
    localparam int WORD_W    = 12;
    localparam int CODE_W    = 3;
    localparam int NCODES    = 1 << CODE_W;

    typedef enum logic [2:0] {
        ST_HDR, ST_ADDR, ST_PAD, ST_PIX, ST_WORD, ST_SKIP
    } frame_st_e;

    typedef struct packed {
        logic              rd;
        logic [CODE_W-1:0] code;
    } hdr_t;

    localparam logic [CODE_W-1:0] CODE_PIX  = 3'b000;
    localparam logic [CODE_W-1:0] CODE_RSVD = 3'b001;

    function automatic logic word_present(input int code);
        return (code != int'(CODE_PIX)) && (code != int'(CODE_RSVD));
    endfunction

    function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
        return (int'(a) >= PIX_DEPTH - 1) ? '0 : a + 1'b1;
    endfunction
endpackage

// File: rtl/pixspi_sync.sv
module pixspi_sync (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic active,
    output logic mosi_s
);
    localparam int NSIG = 3;
    logic [NSIG-1:0] st1, st2;
    logic            sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1   <= 3'b010;
            st2   <= 3'b010;
            sck_d <= 1'b0;
        end else begin
            st1   <= {mosi_i, cs_n_i, sclk_i};
            st2   <= st1;
            sck_d <= st2[0];
        end
    end

    assign sck_rise = st2[0] & ~sck_d;
    assign sck_fall = ~st2[0] & sck_d;
    assign active   = ~st2[1];
    assign mosi_s   = st2[2];
endmodule

// File: rtl/pixspi_frame.sv
module pixspi_frame
    import pixspi_pkg::*;
#(
    parameter int DEPTH = PIX_DEPTH,
    parameter int AW    = ADDR_W,
    parameter int WW    = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              active,
    input  logic              mosi_s,
    input  logic              pix_rbit,
    input  logic [WW-1:0]     word_rdata,
    output logic [AW-1:0]     pix_addr,
    output logic              pix_we,
    output logic [AW-1:0]     pix_waddr,
    output logic              pix_wbit,
    output logic [CODE_W-1:0] word_code,
    output logic              word_we,
    output logic [WW-1:0]     word_wdata,
    output logic              miso
);
    localparam int CW = $clog2((WW > AW ? WW : AW) + 1);

    frame_st_e      st;
    logic [CW-1:0]  cnt;
    logic [2:0]     hsh;
    hdr_t           hdr;
    logic [WW-1:0]  acc;
    logic [CW-1:0]  ridx;

    assign word_code = hdr.code;
    assign ridx      = CW'(WW - 1) - cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st       <= ST_HDR;
            cnt      <= '0;
            hsh      <= '0;
            hdr      <= '0;
            acc      <= '0;
            pix_addr <= '0;
            pix_we   <= 1'b0;
            word_we  <= 1'b0;
            miso     <= 1'b0;
        end else begin
            pix_we  <= 1'b0;
            word_we <= 1'b0;
            if (sck_rise) begin
                cnt <= cnt + 1'b1;
                unique case (st)
                    ST_HDR: begin
                        hsh <= {hsh[1:0], mosi_s};
                        if (cnt == CW'(3)) begin
                            hdr <= '{rd: hsh[2], code: {hsh[1:0], mosi_s}};
                            cnt <= '0;
                            st  <= ({hsh[1:0], mosi_s} == CODE_PIX) ? ST_ADDR : ST_WORD;
                        end
                    end
                    ST_ADDR: begin
                        pix_addr <= {pix_addr[AW-2:0], mosi_s};
                        if (cnt == CW'(AW - 1)) begin
                            cnt <= '0;
                            st  <= ST_PAD;
                        end
                    end
                    ST_PAD: begin
                        if (cnt == CW'(1)) begin
                            st <= ST_PIX;
                            if (int'(pix_addr) >= DEPTH) pix_addr <= '0;
                        end
                    end
                    ST_PIX: begin
                        cnt       <= '0;
                        pix_we    <= ~hdr.rd;
                        pix_waddr <= pix_addr;
                        pix_wbit  <= mosi_s;
                        pix_addr  <= addr_step(pix_addr);
                    end
                    ST_WORD: begin
                        acc <= {acc[WW-2:0], mosi_s};
                        if (cnt == CW'(WW - 1)) begin
                            st         <= ST_SKIP;
                            word_we    <= ~hdr.rd && word_present(int'(hdr.code));
                            word_wdata <= {acc[WW-2:0], mosi_s};
                        end
                    end
                    default: cnt <= cnt;
                endcase
            end
            if (sck_fall) begin
                if (hdr.rd && st == ST_PIX)
                    miso <= pix_rbit;
                else if (hdr.rd && st == ST_WORD)
                    miso <= word_rdata[ridx];
                else
                    miso <= 1'b0;
            end
        end
    end

    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !active |=> !miso) else $error("miso not idle");   // R1
    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && !sck_fall) |=> $stable(miso)) else $error("miso moved off falling edge");   // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && sck_rise && st == ST_PIX) |=> (pix_addr == addr_step($past(pix_addr)))) else $error("bad step");   // R4
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PIX) |-> (int'(pix_addr) < DEPTH)) else $error("addr out of range");   // R5
endmodule

// File: rtl/pixspi_pixmem.sv
module pixspi_pixmem
    import pixspi_pkg::*;
#(
    parameter int DEPTH = PIX_DEPTH,
    parameter int AW    = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr,
    output logic          rbit
);
    logic [DEPTH-1:0] cells;

    always_ff @(posedge clk) begin
        if (rst)
            cells <= '0;
        else if (we && int'(waddr) < DEPTH)
            cells[waddr] <= wbit;
    end

    assign rbit = (int'(raddr) < DEPTH) ? cells[raddr] : 1'b0;

    AST_WADDR_OK: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < DEPTH)) else $error("pixel write out of range");   // R5
endmodule

// File: rtl/pixspi_wordbank.sv
module pixspi_wordbank
    import pixspi_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CODE_W-1:0] code,
    input  logic [WW-1:0]     wdata,
    output logic [WW-1:0]     rdata
);
    logic [WW-1:0] words [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_word
        if (word_present(g)) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst)
                    words[g] <= '0;
                else if (we && code == CODE_W'(g))
                    words[g] <= wdata;
            end
        end else begin : g_zero
            assign words[g] = '0;
        end
    end

    assign rdata = words[code];

    AST_NO_RSVD_WR: assert property (@(posedge clk) disable iff (rst)
        we |-> (code != CODE_RSVD && code != CODE_PIX)) else $error("write to absent word");   // R8
endmodule

// File: rtl/pixspi_cmd_dec.sv
module pixspi_cmd_dec
    import pixspi_pkg::*;
#(
    parameter int DEPTH = PIX_DEPTH,
    parameter int AW    = ADDR_W,
    parameter int WW    = WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    logic              sck_rise, sck_fall, active, mosi_s;
    logic              pix_rbit, pix_we, pix_wbit;
    logic [AW-1:0]     pix_addr, pix_waddr;
    logic [CODE_W-1:0] word_code;
    logic              word_we;
    logic [WW-1:0]     word_wdata, word_rdata;

    pixspi_sync u_sync (
        .clk(clk), .rst(rst), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .active(active), .mosi_s(mosi_s)
    );

    pixspi_frame #(.DEPTH(DEPTH), .AW(AW), .WW(WW)) u_frame (
        .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .active(active), .mosi_s(mosi_s), .pix_rbit(pix_rbit), .word_rdata(word_rdata),
        .pix_addr(pix_addr), .pix_we(pix_we), .pix_waddr(pix_waddr), .pix_wbit(pix_wbit),
        .word_code(word_code), .word_we(word_we), .word_wdata(word_wdata), .miso(spi_miso)
    );

    pixspi_pixmem #(.DEPTH(DEPTH), .AW(AW)) u_pix (
        .clk(clk), .rst(rst), .we(pix_we), .waddr(pix_waddr), .wbit(pix_wbit),
        .raddr(pix_addr), .rbit(pix_rbit)
    );

    pixspi_wordbank #(.WW(WW)) u_words (
        .clk(clk), .rst(rst), .we(word_we), .code(word_code), .wdata(word_wdata),
        .rdata(word_rdata)
    );
endmodule

// File: tb/pixspi_cmd_dec_tb.sv
module pixspi_cmd_dec_tb_top;
    localparam int CLK_NS = 10;
    localparam int H      = 6;
    localparam int DEPTH  = 380;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic mon_en  = 1'b0;
    logic exp_q[$];
    string tag_q[$];

    logic       pix_m [DEPTH];
    logic [11:0] word_m [8];

    always #(CLK_NS/2) clk = ~clk;

    pixspi_cmd_dec dut_i (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // monitor: pops one expected bit per sampled read slot
    always @(posedge spi_sclk) begin
        if (mon_en) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R7: unexpected read slot, got %0b expected none", spi_miso);
            end else begin
                automatic logic e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(spi_miso, e, t);
            end
        end
    end

    task automatic sbit(input logic b, input logic mon);
        spi_mosi = b;
        repeat (H) @(negedge clk);
        mon_en = mon;
        spi_sclk = 1'b1;
        repeat (H) @(negedge clk);
        mon_en = 1'b0;
        spi_sclk = 1'b0;
    endtask

    task automatic cs_lo();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4*H) @(negedge clk);
    endtask

    task automatic header(input logic rd, input logic [2:0] code);
        sbit(rd, 1'b0);
        for (int i = 2; i >= 0; i--) sbit(code[i], 1'b0);
    endtask

    task automatic word_write(input logic [2:0] code, input logic [11:0] v, input int extra);
        cs_lo();
        header(1'b0, code);
        for (int i = 11; i >= 0; i--) sbit(v[i], 1'b0);
        for (int i = 0; i < extra; i++) sbit(~v[i % 12], 1'b0);
        cs_hi();
        if (code > 3'd1) word_m[code] = v;
    endtask

    task automatic word_read(input logic [2:0] code, input string tag);
        cs_lo();
        header(1'b1, code);
        for (int i = 11; i >= 0; i--) begin
            exp_q.push_back(code > 3'd1 ? word_m[code][i] : 1'b0);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < 12; i++) sbit(1'b0, 1'b1);
        cs_hi();
    endtask

    function automatic int wrap_start(input int a);
        return (a >= DEPTH) ? 0 : a;
    endfunction

    function automatic logic pat(input int i, input int seed);
        return ((i * seed + (i >> 2)) % 3) == 1;
    endfunction

    task automatic pix_write(input int start, input int n, input int seed, input logic padv);
        automatic logic [9:0] a = 10'(start);
        automatic int p = wrap_start(start);
        cs_lo();
        header(1'b0, 3'b000);
        for (int i = 9; i >= 0; i--) sbit(a[i], 1'b0);
        sbit(padv, 1'b0);
        sbit(padv, 1'b0);
        for (int i = 0; i < n; i++) begin
            sbit(pat(i, seed), 1'b0);
            pix_m[p] = pat(i, seed);
            p = (p + 1) % DEPTH;
        end
        cs_hi();
    endtask

    task automatic pix_read(input int start, input int n, input logic padv, input string tag);
        automatic logic [9:0] a = 10'(start);
        automatic int p = wrap_start(start);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(pix_m[p]);
            tag_q.push_back(tag);
            p = (p + 1) % DEPTH;
        end
        cs_lo();
        header(1'b1, 3'b000);
        for (int i = 9; i >= 0; i--) sbit(a[i], 1'b0);
        sbit(padv, 1'b0);
        sbit(~padv, 1'b0);
        for (int i = 0; i < n; i++) sbit(1'b0, 1'b1);
        cs_hi();
    endtask

    initial begin
        #(CLK_NS * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) pix_m[i] = 1'b0;
        for (int i = 0; i < 8; i++) word_m[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R10 / R1: reset state and idle MISO
        check(spi_miso, 1'b0, "R1 idle miso");
        for (int c = 2; c < 8; c++) word_read(3'(c), "R10 word reset");
        pix_read(0, 8, 1'b0, "R10 pixel reset");

        // R2 / R6: round trip on every control word, MSB first
        for (int c = 2; c < 8; c++) word_write(3'(c), 12'(12'hA53 ^ (c * 12'h111)), 0);
        for (int c = 2; c < 8; c++) word_read(3'(c), "R6 R2 word round trip");

        // R8: reserved code
        word_write(3'b001, 12'hFFF, 0);
        word_read(3'b001, "R8 reserved reads zero");
        word_read(3'b010, "R8 neighbour untouched");

        // R9: early select release
        cs_lo();
        header(1'b0, 3'b011);
        for (int i = 0; i < 5; i++) sbit(1'b1, 1'b0);
        cs_hi();
        word_read(3'b011, "R9 partial write discarded");
        check(spi_miso, 1'b0, "R1 idle miso after abort");

        // R6: extra bits beyond twelve ignored
        word_write(3'b100, 12'h3C5, 4);
        word_read(3'b100, "R6 extra bits ignored");

        // R3 / R4: burst write and read-back, padding of both polarities
        pix_write(10, 24, 5, 1'b1);
        pix_read(10, 24, 1'b0, "R3 R4 burst read-back");
        pix_write(100, 40, 7, 1'b0);
        pix_read(98, 44, 1'b1, "R4 burst overlapping");

        // R5: wrap past the last entry and oversize start address
        pix_write(376, 8, 3, 1'b0);
        pix_read(374, 12, 1'b0, "R5 wrap after last");
        pix_write(700, 6, 11, 1'b1);
        pix_read(0, 8, 1'b0, "R5 oversize start");
        pix_read(1000, 4, 1'b0, "R5 oversize read start");

        // R7: first data bit and word reads remain intact after pixel traffic
        word_read(3'b111, "R7 first bit valid");

        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R7: got %0d unread slots expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule